// File: doc/BRIEF.md
# Programmable Video Line Delay Bank

This block holds up to eight video line delays in one shared pixel memory. Together they supply the row taps of a two dimensional filter window. Each delay is a circular buffer, and every delay is addressed by one common pointer. The line length is set in a register. The memory is divided into eight equal banks. In eight-line mode each line owns one bank. In four-line mode each line owns a pair of banks, so a line can be twice as long.

The lines form two groups, each holding half of the lines. The first group always takes pixels from port A. The second group either continues the chain from the last line of the first group or takes pixels from port B, which makes interlaced and frame-to-frame processing possible. A bypass input skips the first line of the first group. A horizontal reset input clears the pointer and freezes every line while it is high. A delayed copy of that input is produced with a programmable lag. In loop-out mode, port B's companion output carries the last line's data and asserts its drive enable.

Top module: `ldb_line_bank`

## Requirements
- R1: After synchronous reset, `taps_o`, `delsync_o` and `pix_b_oe` are all zero. The reset configuration is: length field 0, sync field 0, mode 0 (four lines, series).
- R2: While `hres_i` is low, a line of effective length L presents on its tap the pixel it received L clock edges earlier. A length field of 0 behaves as length 1.
- R3: The effective length is clamped to the mode's maximum: MAX_LEN in four-line mode and MAX_LEN/2 in eight-line mode.
- R4: In eight-line series mode, line k (k = 0..7) is fed from line k-1 and line 0 is fed from `pix_a_i`. Line k appears at `taps_o[8k+7:8k]`.
- R5: In four-line mode only lines 0..3 exist, and `taps_o` bits for lines 4..7 read zero.
- R6: With the split bit set and loop-out clear, the first line of the second group (line 4 with eight lines, line 2 with four) is fed from `pix_b_i`.
- R7: While `bypass_i` is high, line 1 is fed from `pix_a_i` instead of from line 0.
- R8: While `hres_i` is high, the shared pointer is cleared to zero, no line memory is written, and the taps hold their values.
- R9: All lines share one read-before-write pointer. The pointer advances once per clock with `hres_i` low and wraps to zero after it reaches L-1.
- R10: `delsync_o` equals `hres_i` delayed by N clocks, where N is the sync delay field. A field value of 0 behaves as 1.
- R11: With the loop-out bit set, `pix_b_oe` is high, `pix_b_o` carries the last line's tap, and the second group is chained in series whatever the split bit says.
- R12: Register writes take effect on the rising edge where `cfg_we` is high. The register map is: address 0 holds the length in `cfg_wdata[LEN_W-1:0]`; address 1 holds the sync delay in `cfg_wdata[SW-1:0]`; address 2 holds the mode, with bit 0 for eight lines, bit 1 for split and bit 2 for loop-out. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| pix_a_i | input | PIX_W | Pixel input to the first group |
| pix_b_i | input | PIX_W | Pixel input to the second group in split mode |
| hres_i | input | 1 | Horizontal reset: clears the pointer and freezes the lines |
| bypass_i | input | 1 | Skip line 0 when high |
| taps_o | output | 8*PIX_W | Line tap outputs, line k at bits [k*PIX_W +: PIX_W] |
| pix_b_o | output | PIX_W | Last line's tap for loop-out |
| pix_b_oe | output | 1 | Drive enable for the port B output |
| delsync_o | output | 1 | Delayed copy of hres_i |

## Verification
A random pixel stream is sent through each line configuration: four and eight lines, series, split, bypass and loop-out. A reference built on the address-level behaviour predicts every tap. Series streams catch wrong chaining or an off-by-one length. Split streams carry different values on A and B, which exposes a mixed-up group input. Random horizontal reset pulses in mid-line expose a pointer that is not cleared or lines that keep shifting. Lengths above the mode limit and equal to zero check the clamping. Several sync delay values, driven with random sync patterns, separate the delay amounts.

// File: rtl/ldb_pkg.sv
package ldb_pkg;

    localparam int LDB_LINES = 8;

    typedef struct packed {
        logic loop_out;
        logic split;
        logic eight;
    } ldb_mode_t;

    typedef enum logic [1:0] {
        REG_LEN  = 2'd0,
        REG_SYNC = 2'd1,
        REG_MODE = 2'd2
    } ldb_reg_e;

endpackage

// File: rtl/ldb_cfg_regs.sv
module ldb_cfg_regs
    import ldb_pkg::*;
#(
    parameter int MAX_LEN  = 256,
    parameter int SYNC_MAX = 32,
    localparam int LEN_W   = $clog2(MAX_LEN) + 1,
    localparam int SW      = $clog2(SYNC_MAX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [15:0]      wdata,
    output logic [LEN_W-1:0] len_eff,
    output logic [SW-1:0]    sync_eff,
    output ldb_mode_t        mode
);

    localparam logic [LEN_W-1:0] CAP4 = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] CAP8 = LEN_W'(MAX_LEN / 2);

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [SW-1:0]    sdly;
        ldb_mode_t        mode;
    } regs_t;

    regs_t r_d, r_q;
    logic [LEN_W-1:0] cap;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (ldb_reg_e'(addr))
                REG_LEN:  r_d.len  = wdata[LEN_W-1:0];
                REG_SYNC: r_d.sdly = wdata[SW-1:0];
                REG_MODE: r_d.mode = ldb_mode_t'(wdata[2:0]);
                default:  r_d = r_q;
            endcase
        end
        cap = r_q.mode.eight ? CAP8 : CAP4;
        if (r_q.len == '0)
            len_eff = LEN_W'(1);
        else if (r_q.len > cap)
            len_eff = cap;
        else
            len_eff = r_q.len;
        sync_eff = (r_q.sdly == '0) ? SW'(1) : r_q.sdly;
        mode     = r_q.mode;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

endmodule

// File: rtl/ldb_ram_bank.sv
module ldb_ram_bank #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] mem [DEPTH];

    // read-before-write: dout gets the old word at addr
    always_ff @(posedge clk) begin
        if (rst)     dout <= '0;
        else if (en) dout <= mem[addr];
    end

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= din;
    end

endmodule

// File: rtl/ldb_sync_delay.sv
module ldb_sync_delay #(
    parameter int SYNC_MAX = 32,
    localparam int SW      = $clog2(SYNC_MAX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_i,
    input  logic [SW-1:0] sel,
    output logic          sync_o
);

    logic [SYNC_MAX-1:0] sr_d, sr_q;

    always_comb begin
        sr_d   = {sr_q[SYNC_MAX-2:0], sync_i};
        sync_o = sr_q[sel - 1'b1];
    end

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= sr_d;
    end

endmodule

// File: rtl/ldb_line_bank.sv
module ldb_line_bank
    import ldb_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int MAX_LEN  = 256,
    parameter int SYNC_MAX = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_addr,
    input  logic [15:0]                  cfg_wdata,
    input  logic [PIX_W-1:0]             pix_a_i,
    input  logic [PIX_W-1:0]             pix_b_i,
    input  logic                         hres_i,
    input  logic                         bypass_i,
    output logic [LDB_LINES*PIX_W-1:0]   taps_o,
    output logic [PIX_W-1:0]             pix_b_o,
    output logic                         pix_b_oe,
    output logic                         delsync_o
);

    localparam int NBANK = LDB_LINES;
    localparam int PA    = $clog2(MAX_LEN);
    localparam int LEN_W = PA + 1;
    localparam int SW    = $clog2(SYNC_MAX);
    localparam int HALF  = MAX_LEN / 2;
    localparam int HA    = PA - 1;

    typedef struct packed {
        logic [PA-1:0] ptr;
        logic          hsel;
    } st_t;

    st_t s_d, s_q;

    logic [LEN_W-1:0] len_eff;
    logic [SW-1:0]    sync_eff;
    ldb_mode_t        mode;

    logic [PIX_W-1:0] dout     [NBANK];
    logic [PIX_W-1:0] line_out [NBANK];
    logic [PIX_W-1:0] line_in  [NBANK];
    logic [PIX_W-1:0] bank_din [NBANK];
    logic [NBANK-1:0] bank_we;
    logic             advance;
    logic             wrap;
    logic [LEN_W-1:0] last_idx;
    int               half;
    logic [PA-1:0]    ptr_cur;
    logic             eight_mode;

    ldb_cfg_regs #(.MAX_LEN(MAX_LEN), .SYNC_MAX(SYNC_MAX)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .len_eff  (len_eff),
        .sync_eff (sync_eff),
        .mode     (mode)
    );

    ldb_sync_delay #(.SYNC_MAX(SYNC_MAX)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sync_i (hres_i),
        .sel    (sync_eff),
        .sync_o (delsync_o)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ldb_ram_bank #(.DEPTH(HALF), .DW(PIX_W)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .en   (advance),
            .we   (bank_we[b]),
            .addr (s_q.ptr[HA-1:0]),
            .din  (bank_din[b]),
            .dout (dout[b])
        );
        assign taps_o[b*PIX_W +: PIX_W] = line_out[b];
    end

    always_comb begin
        advance = !hres_i;
        half    = mode.eight ? NBANK / 2 : NBANK / 4;

        // tap selection: one bank per line, or a bank pair per line
        for (int k = 0; k < NBANK; k++)
            line_out[k] = mode.eight ? dout[k] : '0;
        if (!mode.eight) begin
            for (int j = 0; j < NBANK / 2; j++)
                line_out[j] = s_q.hsel ? dout[2*j+1] : dout[2*j];
        end

        // line input routing
        line_in[0] = pix_a_i;
        for (int k = 1; k < NBANK; k++) begin
            if (k == 1 && bypass_i)
                line_in[k] = pix_a_i;
            else if (k == half && mode.split && !mode.loop_out)
                line_in[k] = pix_b_i;
            else
                line_in[k] = line_out[k-1];
        end

        for (int b = 0; b < NBANK; b++) begin
            bank_din[b] = mode.eight ? line_in[b] : line_in[b/2];
            bank_we[b]  = advance &&
                          (mode.eight || (1'(b % 2) == s_q.ptr[PA-1]));
        end

        last_idx = len_eff - 1'b1;
        wrap     = {1'b0, s_q.ptr} >= last_idx;

        s_d = s_q;
        if (!advance) begin
            s_d.ptr = '0;
        end else begin
            s_d.ptr  = wrap ? '0 : s_q.ptr + 1'b1;
            s_d.hsel = s_q.ptr[PA-1];
        end

        pix_b_o    = mode.eight ? line_out[NBANK-1] : line_out[NBANK/2-1];
        pix_b_oe   = mode.loop_out;
        ptr_cur    = s_q.ptr;
        eight_mode = mode.eight;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

endmodule

// File: rtl/ldb_line_bank_chk.sv
module ldb_line_bank_chk #(
    parameter int PIX_W = 8,
    parameter int NL    = 8,
    parameter int PA    = 8,
    parameter int SW    = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              hres_i,
    input logic              cfg_we,
    input logic [NL*PIX_W-1:0] taps_o,
    input logic              delsync_o,
    input logic [PA-1:0]     ptr_cur,
    input logic [SW-1:0]     sync_eff,
    input logic              eight_mode
);

    p_hres_clear_r8: assert property (@(posedge clk) disable iff (rst)
        hres_i |=> ptr_cur == '0);

    p_taps_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (hres_i && !cfg_we) |=> $stable(taps_o));

    p_ptr_step_r9: assert property (@(posedge clk) disable iff (rst)
        (!hres_i) |=> (ptr_cur == '0 || ptr_cur == PA'($past(ptr_cur) + 1'b1)));

    p_unused_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !eight_mode |-> taps_o[NL*PIX_W-1 : NL*PIX_W/2] == '0);

    p_sync_one_r10: assert property (@(posedge clk) disable iff (rst)
        (sync_eff == SW'(1) && !cfg_we) |=> delsync_o == $past(hres_i));

endmodule

bind ldb_line_bank ldb_line_bank_chk #(
    .PIX_W(PIX_W), .NL(NBANK), .PA(PA), .SW(SW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hres_i     (hres_i),
    .cfg_we     (cfg_we),
    .taps_o     (taps_o),
    .delsync_o  (delsync_o),
    .ptr_cur    (ptr_cur),
    .sync_eff   (sync_eff),
    .eight_mode (eight_mode)
);

// File: tb/tb_ldb_line_bank.sv
module tb_ldb_line_bank;

    localparam int CLK_PERIOD = 10;
    localparam int PW   = 8;
    localparam int MAXL = 256;
    localparam int SMAX = 32;
    localparam int NL   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [PW-1:0] pix_a = '0, pix_b = '0;
    logic hres = 1'b0, byp = 1'b0;
    logic [NL*PW-1:0] taps_o;
    logic [PW-1:0] pix_b_o;
    logic pix_b_oe, delsync_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldb_line_bank #(.PIX_W(PW), .MAX_LEN(MAXL), .SYNC_MAX(SMAX)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_a_i(pix_a), .pix_b_i(pix_b),
        .hres_i(hres), .bypass_i(byp), .taps_o(taps_o), .pix_b_o(pix_b_o),
        .pix_b_oe(pix_b_oe), .delsync_o(delsync_o)
    );

    typedef struct {
        logic [NL*PW-1:0] taps;
        logic [NL-1:0]    tmask;
        int               nlines;
        logic             ds;
        logic             oe;
        logic [PW-1:0]    pb;
        logic             pbv;
        string            tag;
    } exp_t;

    exp_t q[$];
    int n_checks = 0;
    int n_fail = 0;
    string cur_tag = "R2";

    // reference state
    logic [PW-1:0] mem [NL][MAXL];
    bit            mv  [NL][MAXL];
    logic [PW-1:0] tp  [NL];
    bit            tv  [NL];
    bit            hh  [SMAX];
    int ptr = 0;
    int len_raw = 0, sync_raw = 0;
    bit m_eight = 0, m_split = 0, m_loop = 0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic invalidate();
        for (int k = 0; k < NL; k++) begin
            tv[k] = 0;
            for (int i = 0; i < MAXL; i++) mv[k][i] = 0;
        end
    endtask

    // driver: called at a negedge, drives one cycle, models the next edge
    task automatic step(input logic [PW-1:0] a, input logic [PW-1:0] b,
                        input logic h, input logic bp,
                        input logic we = 1'b0, input logic [1:0] ad = 2'd0,
                        input logic [15:0] wd = 16'd0);
        exp_t e;
        int n, half, len, cap;
        logic [PW-1:0] lin [NL];
        bit            lv  [NL];
        pix_a = a; pix_b = b; hres = h; byp = bp;
        cfg_we = we; cfg_addr = ad; cfg_wdata = wd;

        n    = m_eight ? 8 : 4;
        half = n / 2;
        cap  = m_eight ? MAXL/2 : MAXL;
        len  = (len_raw == 0) ? 1 : (len_raw > cap ? cap : len_raw);
        if (!h) begin
            lin[0] = a; lv[0] = 1;
            for (int k = 1; k < n; k++) begin
                if (k == 1 && bp) begin lin[k] = a; lv[k] = 1; end
                else if (k == half && m_split && !m_loop) begin lin[k] = b; lv[k] = 1; end
                else begin lin[k] = tp[k-1]; lv[k] = tv[k-1]; end
            end
            for (int k = 0; k < n; k++) begin
                tp[k] = mem[k][ptr]; tv[k] = mv[k][ptr];
                mem[k][ptr] = lin[k]; mv[k][ptr] = lv[k];
            end
            ptr = (ptr >= len - 1) ? 0 : ptr + 1;
        end else begin
            ptr = 0;
        end
        if (we) begin
            case (ad)
                2'd0: begin len_raw = int'(wd[8:0]); invalidate(); end
                2'd1: sync_raw = int'(wd[4:0]);
                2'd2: begin m_eight = wd[0]; m_split = wd[1]; m_loop = wd[2]; invalidate(); end
                default: ;
            endcase
        end
        n = m_eight ? 8 : 4;
        for (int k = n; k < NL; k++) begin tp[k] = '0; tv[k] = 1; end
        for (int i = SMAX-1; i > 0; i--) hh[i] = hh[i-1];
        hh[0] = h;

        for (int k = 0; k < NL; k++) begin
            e.taps[k*PW +: PW] = tp[k];
            e.tmask[k] = tv[k];
        end
        e.nlines = n;
        e.ds  = hh[(sync_raw == 0 ? 1 : sync_raw) - 1];
        e.oe  = m_loop;
        e.pb  = tp[n-1];
        e.pbv = m_loop && tv[n-1];
        e.tag = cur_tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] ad, input logic [15:0] wd);
        step(8'h00, 8'h00, 1'b1, 1'b0, 1'b1, ad, wd);
    endtask

    task automatic run(input int nc, input logic bp, input int hprob);
        for (int i = 0; i < nc; i++) begin
            logic h;
            h = (hprob > 0) && (($urandom % hprob) == 0);
            step(PW'($urandom), PW'($urandom), h, bp);
        end
    endtask

    // monitor: compares outputs after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                for (int k = 0; k < NL; k++) begin
                    if (e.tmask[k])
                        chk((k >= e.nlines) ? "R5" : e.tag,
                            16'(taps_o[k*PW +: PW]), 16'(e.taps[k*PW +: PW]));
                end
                chk("R10", 16'(delsync_o), 16'(e.ds));
                chk("R11", 16'(pix_b_oe), 16'(e.oe));
                if (e.pbv) chk("R11", 16'(pix_b_o), 16'(e.pb));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < NL; k++) begin tp[k] = '0; tv[k] = 1; end
        for (int i = 0; i < SMAX; i++) hh[i] = 0;
        invalidate();
        for (int k = 0; k < NL; k++) tv[k] = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", 16'(taps_o), 16'd0);
        chk("R1", 16'(taps_o >> 16), 16'd0);
        chk("R1", 16'(taps_o >> 32), 16'd0);
        chk("R1", 16'(taps_o >> 48), 16'd0);
        chk("R1", 16'(delsync_o), 16'd0);
        chk("R1", 16'(pix_b_oe), 16'd0);

        cur_tag = "R2"; cfg(2'd0, 16'd5); run(60, 0, 0);
        cfg(2'd0, 16'd0); run(20, 0, 0);
        cur_tag = "R4"; cfg(2'd2, 16'h1); cfg(2'd0, 16'd7); run(80, 0, 0);
        cur_tag = "R7"; run(80, 1, 0);
        cur_tag = "R6"; cfg(2'd2, 16'h3); cfg(2'd0, 16'd3); run(60, 0, 0);
        cfg(2'd2, 16'h2); cfg(2'd0, 16'd4); run(40, 0, 0);
        cur_tag = "R3"; cfg(2'd2, 16'h0); cfg(2'd0, 16'd300); run(4*256 + 40, 0, 0);
        cfg(2'd2, 16'h1); cfg(2'd0, 16'd200); run(8*128 + 40, 0, 0);
        cur_tag = "R8"; cfg(2'd0, 16'd9); run(200, 0, 7);
        cur_tag = "R9"; cfg(2'd2, 16'h0); cfg(2'd0, 16'd6); run(200, 1, 40);
        cur_tag = "R10"; cfg(2'd1, 16'd0); run(30, 0, 3);
        cfg(2'd1, 16'd5); run(60, 0, 3);
        cfg(2'd1, 16'd31); run(80, 0, 3);
        cur_tag = "R11"; cfg(2'd2, 16'h7); cfg(2'd0, 16'd4); run(60, 0, 0);
        cfg(2'd2, 16'h6); run(40, 0, 0);
        cur_tag = "R12"; run(10, 0, 0);
        cfg(2'd3, 16'hFFFF); run(30, 0, 0);

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule